// File: doc/BRIEF.md
# Register-mapped serial port front end

This block is the host-facing side of a serial port. A 32-bit word-addressed register bus gives software access to a few control words, one transmit data register and two status/data windows. It also gives access to a small interrupt unit with raw, enable, acknowledge and gated views. Bit-level line serialization and baud timing live elsewhere. Here the transmit direction is a byte stream going out, and the receive direction is a byte stream coming in. Incoming bytes collect in a 16-entry circular FIFO until software reads them.

Both streams use valid/ready. On the transmit stream, `tx_valid` rises the cycle after a data-out write and stays asserted with `tx_data` unchanged until the cycle in which `tx_ready` is high. A second data-out write made before that handshake replaces the byte that is waiting. On the receive stream, a byte is taken on every clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is withheld while reception is disabled or the FIFO is full, so the upstream source has to hold its byte. The two status/data windows return the same word. One of them also removes the oldest byte, and the other only looks at it. One level-sensitive interrupt line reports any raw interrupt bit whose enable bit is set.

A bus access is one cycle with `bus_sel` high. Write data is taken on that edge. Read data appears on `bus_rdata` from the next cycle onward and is built from the state as it was before the access took effect.

Top module: `sercon_top`

## Requirements
- R1: After reset the receive-control word reads 0x00010000. Every other storage word and the raw interrupt word read 0. The FIFO is empty, `irq`, `tx_valid` and `rx_ready` are low, and a peek returns 0x01400000.
- R2: The words at byte offsets 0x00 (transmit control), 0x04 (DMA enable), 0x08 (receive control), 0x1C (data out), 0x2C (interrupt enable) and 0x30 (acknowledge) read back the last 32-bit value stored in them. The acknowledge word holds the value after the adjustment of R10.
- R3: `rx_ready` is high exactly when receive-control bit 3 is 1 and the FIFO holds fewer than 16 bytes. A byte offered while `rx_ready` is low is not stored.
- R4: The FIFO delivers up to 16 bytes in arrival order, and its pointers wrap around.
- R5: A status/data word has the oldest byte in bits [7:0] (0 when the FIFO is empty), data-available in bit 16 (FIFO non-empty), and 1 in bits 22 and 24. All other bits are 0.
- R6: A read at 0x20 removes the oldest byte if there is one. A read at 0x24, or a read at 0x20 on an empty FIFO, leaves the FIFO unchanged.
- R7: A pop and an accepted push in the same cycle leave the byte count unchanged. The read returns the byte that was oldest before that edge.
- R8: Raw interrupt bit 3 reads 1 exactly when the FIFO is non-empty, whatever value is written to the raw word.
- R9: A write to 0x1C places its low byte on the transmit stream and holds it there until the handshake. It sets raw bits 0 and 1 and marks a transmit as pending.
- R10: A write of value V to 0x30 clears the raw bits that are set in V. While a transmit is pending, bit 0 is first removed from V and the pending mark is cleared.
- R11: A read at 0x38 returns raw AND enable. `irq` is high exactly when that value is non-zero.
- R12: Writes to 0x34 replace the raw word apart from bit 3. Writes to 0x20, 0x24 and 0x38 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address, byte address bits [5:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_valid | output | 1 | Transmit byte is waiting |
| tx_ready | input | 1 | Transmit sink takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receiver can take a byte |
| rx_data | input | 8 | Receive byte |
| irq | output | 1 | Level interrupt |

## Verification
The FIFO is filled to every level from 1 to 16 and then drained with popping reads. The bytes are distinct at each level, so losing one, duplicating one or returning them out of order all show up. Each level starts at a different pointer position, which exercises the wrap. Peeks placed between pops tell the non-destructive window apart from the popping one. A simultaneous pop and push separates a correct count from an off-by-one. A push offered to a full FIFO, and one offered with reception disabled, show that back-pressure is obeyed. The acknowledge path is swept over every 4-bit value, both with and without a pending transmit, followed by a second acknowledge. The enable word is swept over all 16 low-bit values against a fixed raw pattern, which checks the gated view and the line separately.

// File: rtl/sercon_pkg.sv
package sercon_pkg;
  localparam int ADDR_W = 6;              // byte address span 0x00..0x3C
  localparam int IDX_W  = ADDR_W - 2;     // word index width

  // word indexes (byte offset / 4)
  localparam logic [IDX_W-1:0] IX_TXCTL  = 4'h0;
  localparam logic [IDX_W-1:0] IX_DMAEN  = 4'h1;
  localparam logic [IDX_W-1:0] IX_RXCTL  = 4'h2;
  localparam logic [IDX_W-1:0] IX_DOUT   = 4'h7;
  localparam logic [IDX_W-1:0] IX_POP    = 4'h8;
  localparam logic [IDX_W-1:0] IX_PEEK   = 4'h9;
  localparam logic [IDX_W-1:0] IX_IEN    = 4'hB;
  localparam logic [IDX_W-1:0] IX_ACK    = 4'hC;
  localparam logic [IDX_W-1:0] IX_RAW    = 4'hD;
  localparam logic [IDX_W-1:0] IX_GATED  = 4'hE;

  // field positions
  localparam int ST_AVAIL   = 16;
  localparam int ST_TXIDLE  = 22;
  localparam int ST_TXRDY   = 24;
  localparam int RXEN_BIT   = 3;
  localparam int IRQ_RX_BIT = 3;

  localparam logic [31:0] RXCTL_RESET = 32'h0001_0000;
endpackage

// File: rtl/sercon_fifo.sv
module sercon_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sercon_irq.sv
module sercon_irq #(
  parameter int W      = 32,
  parameter int RX_BIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_raw,
  input  logic         wr_ack,
  input  logic         wr_ien,
  input  logic         tx_kick,
  input  logic [W-1:0] wdata,
  input  logic         rx_nonempty,
  output logic [W-1:0] raw,
  output logic [W-1:0] ien,
  output logic [W-1:0] ack_word,
  output logic [W-1:0] gated,
  output logic         irq
);
  localparam logic [W-1:0] RX_M = W'(1) << RX_BIT;
  localparam logic [W-1:0] TX_M = W'(3);

  logic [W-1:0] raw_q;      // bit RX_BIT held at zero, driven live below
  logic         tx_pend;
  logic [W-1:0] ack_adj;

  always_comb begin
    ack_adj = wdata;
    if (tx_pend) ack_adj[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q    <= '0;
      ien      <= '0;
      ack_word <= '0;
      tx_pend  <= 1'b0;
    end else begin
      if (wr_ien) ien <= wdata;
      if (wr_raw) raw_q <= wdata & ~RX_M;
      if (tx_kick) begin
        raw_q   <= (raw_q | TX_M) & ~RX_M;
        tx_pend <= 1'b1;
      end
      if (wr_ack) begin
        ack_word <= ack_adj;
        raw_q    <= raw_q & ~ack_adj & ~RX_M;
        tx_pend  <= 1'b0;
      end
    end
  end

  assign raw   = raw_q | (rx_nonempty ? RX_M : '0);
  assign gated = raw & ien;
  assign irq   = |gated;
endmodule

// File: rtl/sercon_top.sv
module sercon_top
  import sercon_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:2]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [BYTE_W-1:0]   tx_data,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [BYTE_W-1:0]   rx_data,
  output logic                irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              wr_en, rd_en;
  logic [DATA_W-1:0] txctl, dmaen, rxctl, dout;
  logic [BYTE_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty, fifo_full;
  logic              rx_push, rx_pop;
  logic [DATA_W-1:0] raw, ien, ack_word, gated;
  logic [DATA_W-1:0] stat_word, rd_mux;

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  // plain storage words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txctl <= '0;
      dmaen <= '0;
      rxctl <= DATA_W'(RXCTL_RESET);
      dout  <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        IX_TXCTL: txctl <= bus_wdata;
        IX_DMAEN: dmaen <= bus_wdata;
        IX_RXCTL: rxctl <= bus_wdata;
        IX_DOUT:  dout  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // receive path
  assign rx_ready = rxctl[RXEN_BIT] & ~fifo_full;
  assign rx_push  = rx_valid & rx_ready;
  assign rx_pop   = rd_en & (bus_addr == IX_POP);

  sercon_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  // transmit stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr_en && bus_addr == IX_DOUT) begin
      tx_valid <= 1'b1;
      tx_data  <= bus_wdata[BYTE_W-1:0];
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  sercon_irq #(.W(DATA_W), .RX_BIT(IRQ_RX_BIT)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_raw      (wr_en && bus_addr == IX_RAW),
    .wr_ack      (wr_en && bus_addr == IX_ACK),
    .wr_ien      (wr_en && bus_addr == IX_IEN),
    .tx_kick     (wr_en && bus_addr == IX_DOUT),
    .wdata       (bus_wdata),
    .rx_nonempty (~fifo_empty),
    .raw         (raw),
    .ien         (ien),
    .ack_word    (ack_word),
    .gated       (gated),
    .irq         (irq)
  );

  // status/data word
  always_comb begin
    stat_word             = '0;
    stat_word[BYTE_W-1:0] = fifo_empty ? '0 : fifo_head;
    stat_word[ST_AVAIL]   = ~fifo_empty;
    stat_word[ST_TXIDLE]  = 1'b1;
    stat_word[ST_TXRDY]   = 1'b1;
  end

  always_comb begin
    case (bus_addr)
      IX_TXCTL: rd_mux = txctl;
      IX_DMAEN: rd_mux = dmaen;
      IX_RXCTL: rd_mux = rxctl;
      IX_DOUT:  rd_mux = dout;
      IX_POP,
      IX_PEEK:  rd_mux = stat_word;
      IX_IEN:   rd_mux = ien;
      IX_ACK:   rd_mux = ack_word;
      IX_RAW:   rd_mux = raw;
      IX_GATED: rd_mux = gated;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sercon_chk.sv
module sercon_chk
  import sercon_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:2] bus_addr,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic [CW-1:0]     count,
  input logic [31:0]       raw
);
  logic pushing, popping, peeking, kicking;
  assign pushing = rx_valid & rx_ready;
  assign popping = bus_sel & ~bus_wr & (bus_addr == IX_POP);
  assign peeking = bus_sel & ~bus_wr & (bus_addr == IX_PEEK);
  assign kicking = bus_sel & bus_wr & (bus_addr == IX_DOUT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R4
  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pushing && !popping) |=> count == $past(count) + 1'b1); // R3
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (peeking && !pushing) |=> $stable(count)); // R6
  AST_PUSH_POP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pushing && popping) |=> $stable(count)); // R7
  AST_RX_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    raw[IRQ_RX_BIT] == (count != '0)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !kicking) |=> tx_valid && $stable(tx_data)); // R9
  AST_TX_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    kicking |=> raw[1:0] == 2'b11); // R9
endmodule

bind sercon_top sercon_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .count    (fifo_cnt),
  .raw      (raw)
);

// File: tb/sercon_top_test.sv
`timescale 1ns/1ps
module sercon_top_test;
  localparam logic [3:0] A_TXCTL = 4'h0, A_DMA = 4'h1, A_RXCTL = 4'h2, A_DOUT = 4'h7,
                         A_POP = 4'h8, A_PEEK = 4'h9, A_IEN = 4'hB, A_ACK = 4'hC,
                         A_RAW = 4'hD, A_GATED = 4'hE;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic irq;

  int n_chk = 0, n_bad = 0, cyc = 0;

  sercon_top uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  function automatic logic [31:0] stat(bit ne, logic [7:0] b);
    return 32'h0140_0000 | (ne ? (32'h1_0000 | 32'(b)) : 32'h0);
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] vv, re;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_RXCTL, d); check("R1 rxctl", d, 32'h0001_0000);
    rd(A_TXCTL, d); check("R1 txctl", d, 0);
    rd(A_DMA, d);   check("R1 dma", d, 0);
    rd(A_DOUT, d);  check("R1 dout", d, 0);
    rd(A_IEN, d);   check("R1 ien", d, 0);
    rd(A_ACK, d);   check("R1 ack", d, 0);
    rd(A_RAW, d);   check("R1 raw", d, 0);
    rd(A_GATED, d); check("R1 gated", d, 0);
    rd(A_PEEK, d);  check("R1 peek", d, 32'h0140_0000);
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 0);

    // R2 storage words
    wr(A_TXCTL, 32'hA5A5_5A5A); rd(A_TXCTL, d); check("R2 txctl", d, 32'hA5A5_5A5A);
    wr(A_DMA, 32'h1234_5678);   rd(A_DMA, d);   check("R2 dma", d, 32'h1234_5678);
    wr(A_IEN, 32'hF0F0_0000);   rd(A_IEN, d);   check("R2 ien", d, 32'hF0F0_0000);
    wr(A_IEN, 0);

    // R3 disabled receiver refuses
    push(8'h77);
    rd(A_PEEK, d); check("R3 disabled no store", d, stat(0, 0));
    wr(A_RXCTL, 32'h0000_0008);
    rd(A_RXCTL, d); check("R2 rxctl", d, 32'h8);
    check("R3 ready when enabled", rx_ready, 1);

    // R4/R5/R6/R8 fill-level sweep, pointers wander for wrap
    for (int n = 1; n <= 16; n++) begin
      for (int i = 0; i < n; i++) push(8'(n * 17 + i));
      rd(A_RAW, d); check("R8 raw bit3 set", d & 32'h8, 32'h8);
      if (n == 16) begin
        check("R3 ready low when full", rx_ready, 0);
        push(8'hEE);
      end
      for (int i = 0; i < n; i++) begin
        rd(A_PEEK, d); check("R6 peek keeps", d, stat(1, 8'(n * 17 + i)));
        rd(A_POP, d);  check("R4 order", d, stat(1, 8'(n * 17 + i)));
      end
      rd(A_PEEK, d); check("R5 empty word", d, stat(0, 0));
      rd(A_RAW, d);  check("R8 raw bit3 clear", d & 32'h8, 0);
    end

    // R6 pop on empty does nothing
    rd(A_POP, d); check("R6 pop empty", d, stat(0, 0));
    push(8'h5C);
    rd(A_PEEK, d); check("R6 after empty pop", d, stat(1, 8'h5C));
    rd(A_POP, d);  check("R6 single", d, stat(1, 8'h5C));
    rd(A_PEEK, d); check("R6 drained", d, stat(0, 0));

    // R7 simultaneous push and pop
    push(8'h31); push(8'h32); push(8'h33);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = A_POP; rx_valid = 1; rx_data = 8'h34;
    @(negedge clk); d = bus_rdata; bus_sel = 0; rx_valid = 0;
    check("R7 old head", d, stat(1, 8'h31));
    rd(A_POP, d); check("R7 b2", d, stat(1, 8'h32));
    rd(A_POP, d); check("R7 b3", d, stat(1, 8'h33));
    rd(A_POP, d); check("R7 b4", d, stat(1, 8'h34));
    rd(A_PEEK, d); check("R7 count kept", d, stat(0, 0));

    // R9 transmit stream
    wr(A_DOUT, 32'h0000_1ABC);
    check("R9 tx_valid", tx_valid, 1);
    check("R9 tx_data", tx_data, 8'hBC);
    repeat (3) @(negedge clk);
    check("R9 held", {tx_valid, tx_data}, {1'b1, 8'hBC});
    rd(A_RAW, d);  check("R9 raw bits", d, 32'h3);
    rd(A_DOUT, d); check("R2 dout", d, 32'h1ABC);
    tx_ready = 1;
    @(negedge clk); check("R9 handshake done", tx_valid, 0);

    // R10 acknowledge sweep
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 16; v++) begin
        wr(A_ACK, 32'hF);            // clears any pending mark
        wr(A_ACK, 32'hF);
        wr(A_RAW, 32'h7);
        if (p == 1) wr(A_DOUT, 32'h42);
        vv = (p == 1) ? (32'(v) & ~32'h1) : 32'(v);
        re = 32'h7 & ~vv;
        wr(A_ACK, 32'(v));
        rd(A_RAW, d); check("R10 first ack", d, re);
        rd(A_ACK, d); check("R10 ack word", d, vv);
        wr(A_ACK, 32'(v));
        rd(A_RAW, d); check("R10 second ack", d, re & ~32'(v));
      end
    end

    // R11 gating sweep, R12 raw write / ignored writes
    wr(A_RAW, 32'hFFFF_FFFF);
    rd(A_RAW, d); check("R12 raw bit3 ignored", d, 32'hFFFF_FFF7);
    wr(A_RAW, 32'h5);
    for (int m = 0; m < 16; m++) begin
      wr(A_IEN, 32'(m));
      rd(A_GATED, d); check("R11 gated", d, 32'h5 & 32'(m));
      check("R11 irq", irq, ((32'h5 & 32'(m)) != 0));
    end
    wr(A_IEN, 32'h8);
    check("R11 irq off", irq, 0);
    push(8'h99);
    check("R11 irq rx", irq, 1);
    wr(A_GATED, 32'h0);
    wr(A_PEEK, 32'h0);
    wr(A_POP, 32'h0);
    rd(A_GATED, d); check("R12 gated write ignored", d, 32'h8);
    rd(A_PEEK, d);  check("R12 status write ignored", d, stat(1, 8'h99));
    rd(A_POP, d);
    check("R11 irq drop", irq, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule